// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This unit watches the register fields and control bits held in the pipeline registers of a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute with address calculation, memory access, and writeback. An instruction writes at most one register, and that write comes from the memory or writeback stage. The datapath, register file, ALU and memories sit outside this block, and every output is a combinational function of the present inputs.

The unit produces three kinds of output. For the execute stage it gives a bypass select code per source operand, so a result that is already computed can be used before it reaches the register file. It also raises a stall that freezes the program counter and the fetch/decode register, and at the same time asks for a no-op bubble in execute. That happens for the one-cycle load-use gap, and for a decode-stage branch whose compare operand is not ready yet. Finally, since branches are predicted not taken and resolved in decode, it flushes the instruction fetched after a taken branch.

The block has no stream interface. Every pin is a plain control level, and back-pressure is the stall output itself. The register file is assumed to write before it reads, so a writeback-stage result never needs a bypass into decode. Instruction and data memories are separate, so memory traffic never stalls fetch.

Top module: `hzd_unit`

## Requirements
- R1: When an execute-stage source equals the memory-stage destination and that instruction writes a register, the select for that operand is 2'b10.
- R2: When only the writeback-stage destination matches and writes a register, the select is 2'b01. Otherwise it is 2'b00, and 2'b11 never appears.
- R3: When both the memory-stage and the writeback-stage destinations match, the memory-stage code 2'b10 wins.
- R4: Register index 0 is never bypassed, never raises a stall and never drives a decode bypass.
- R5: A load in execute (ex_memread_i high) whose destination equals a decode source that is in use raises stall_o and bubble_o in the same cycle. A source whose use bit is low has no effect.
- R6: A branch in decode whose used source equals the destination of a register-writing instruction in execute raises stall_o and bubble_o.
- R7: A branch in decode whose used source equals the destination of a load in the memory stage raises stall_o. If the memory-stage instruction is not a load, there is no stall and the matching decode bypass bit (id_fwd_a_o for rs, id_fwd_b_o for rt) is 1.
- R8: flush_o is 1 exactly when a branch in decode is taken (br_taken_i high) and no stall is raised. A branch that is not taken never flushes.
- R9: A stall always wins over a flush. While stall_o is high, flush_o is 0, even when br_taken_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_i | input | AW | First source index of the instruction in decode |
| id_rt_i | input | AW | Second source index of the instruction in decode |
| id_use_rs_i | input | 1 | Decode instruction reads its first source |
| id_use_rt_i | input | 1 | Decode instruction reads its second source |
| id_branch_i | input | 1 | Decode instruction is a conditional branch |
| br_taken_i | input | 1 | Branch compare result from decode |
| ex_rs_i | input | AW | First source index in execute |
| ex_rt_i | input | AW | Second source index in execute |
| ex_rd_i | input | AW | Destination index in execute |
| ex_regwrite_i | input | 1 | Execute instruction writes a register |
| ex_memread_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | AW | Destination index in memory stage |
| mem_regwrite_i | input | 1 | Memory-stage instruction writes a register |
| mem_memread_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | AW | Destination index in writeback |
| wb_regwrite_i | input | 1 | Writeback instruction writes a register |
| ex_fwd_a_o | output | 2 | Bypass select, first execute operand |
| ex_fwd_b_o | output | 2 | Bypass select, second execute operand |
| id_fwd_a_o | output | 1 | Take memory-stage result into first branch compare input |
| id_fwd_b_o | output | 1 | Take memory-stage result into second branch compare input |
| stall_o | output | 1 | Hold program counter and fetch/decode register |
| bubble_o | output | 1 | Insert a no-op into execute |
| flush_o | output | 1 | Squash the instruction fetched after a taken branch |

## Verification
The hardest case to reach is a branch caught between two hazards at once: a load sitting in the memory stage and a different producer in execute, both naming the branch's sources, with br_taken_i high so that the flush has to be held off. Directed steps build that case and its neighbours (a load in memory versus an ALU result in memory, the use bits low, register 0). A long phase then draws register indices from only four values, so coincident matches across all three older stages keep occurring. A behavioural model in the bench compares every output on every clock.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned REG_AW = 5;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_ex_bypass.sv
module hzd_ex_bypass
  import hzd_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output logic [1:0]    sel_o
);
  localparam logic [AW-1:0] ZERO_IDX = '0;

  logic hit_mem, hit_wb;
  fwd_sel_e sel;

  assign hit_mem = mem_we_i && (mem_rd_i != ZERO_IDX) && (mem_rd_i == src_i);
  assign hit_wb  = wb_we_i  && (wb_rd_i  != ZERO_IDX) && (wb_rd_i  == src_i);

  // youngest producer first
  always_comb begin
    if (hit_mem)     sel = FWD_EXMEM;
    else if (hit_wb) sel = FWD_MEMWB;
    else             sel = FWD_RF;
  end

  assign sel_o = sel;
endmodule

// File: rtl/hzd_load_interlock.sv
module hzd_load_interlock
  import hzd_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_use_rs_i,
  input  logic          id_use_rt_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_load_i,
  output logic          stall_o
);
  localparam logic [AW-1:0] ZERO_IDX = '0;

  logic dst_live;
  logic need_rs, need_rt;

  assign dst_live = ex_load_i && (ex_rd_i != ZERO_IDX);
  assign need_rs  = id_use_rs_i && (id_rs_i == ex_rd_i);
  assign need_rt  = id_use_rt_i && (id_rt_i == ex_rd_i);
  assign stall_o  = dst_live && (need_rs || need_rt);
endmodule

// File: rtl/hzd_branch_ctrl.sv
module hzd_branch_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic          id_branch_i,
  input  logic          br_taken_i,
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_use_rs_i,
  input  logic          id_use_rt_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic          mem_load_i,
  input  logic          other_stall_i,
  output logic          br_stall_o,
  output logic          fwd_a_o,
  output logic          fwd_b_o,
  output logic          flush_o
);
  localparam int unsigned NSRC = 2;
  localparam logic [AW-1:0] ZERO_IDX = '0;

  logic [AW-1:0] src   [NSRC];
  logic [NSRC-1:0] use_src;
  logic [NSRC-1:0] wait_ex, wait_mem, byp_mem;

  assign src[0]  = id_rs_i;
  assign src[1]  = id_rt_i;
  assign use_src = {id_use_rt_i, id_use_rs_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic live;
    assign live        = id_branch_i && use_src[g] && (src[g] != ZERO_IDX);
    assign wait_ex[g]  = live && ex_we_i && (ex_rd_i == src[g]);
    assign wait_mem[g] = live && mem_we_i && mem_load_i && (mem_rd_i == src[g]);
    assign byp_mem[g]  = live && mem_we_i && !mem_load_i && (mem_rd_i == src[g]);
  end

  assign br_stall_o = |wait_ex || |wait_mem;
  assign fwd_a_o    = byp_mem[0];
  assign fwd_b_o    = byp_mem[1];
  // an unresolved branch must not squash anything
  assign flush_o    = id_branch_i && br_taken_i && !br_stall_o && !other_stall_i;
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_use_rs_i,
  input  logic          id_use_rt_i,
  input  logic          id_branch_i,
  input  logic          br_taken_i,
  input  logic [AW-1:0] ex_rs_i,
  input  logic [AW-1:0] ex_rt_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_regwrite_i,
  input  logic          ex_memread_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_regwrite_i,
  input  logic          mem_memread_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_regwrite_i,
  output logic [1:0]    ex_fwd_a_o,
  output logic [1:0]    ex_fwd_b_o,
  output logic          id_fwd_a_o,
  output logic          id_fwd_b_o,
  output logic          stall_o,
  output logic          bubble_o,
  output logic          flush_o
);
  localparam int unsigned NOPS = 2;

  logic [AW-1:0] ex_src [NOPS];
  logic [1:0]    ex_sel [NOPS];
  logic          ld_stall, br_stall;

  assign ex_src[0] = ex_rs_i;
  assign ex_src[1] = ex_rt_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_byp
    hzd_ex_bypass #(.AW(AW)) byp_i (
      .src_i    (ex_src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_regwrite_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_regwrite_i),
      .sel_o    (ex_sel[g])
    );
  end

  assign ex_fwd_a_o = ex_sel[0];
  assign ex_fwd_b_o = ex_sel[1];

  hzd_load_interlock #(.AW(AW)) ldi_i (
    .id_rs_i     (id_rs_i),
    .id_rt_i     (id_rt_i),
    .id_use_rs_i (id_use_rs_i),
    .id_use_rt_i (id_use_rt_i),
    .ex_rd_i     (ex_rd_i),
    .ex_load_i   (ex_memread_i),
    .stall_o     (ld_stall)
  );

  hzd_branch_ctrl #(.AW(AW)) brc_i (
    .id_branch_i   (id_branch_i),
    .br_taken_i    (br_taken_i),
    .id_rs_i       (id_rs_i),
    .id_rt_i       (id_rt_i),
    .id_use_rs_i   (id_use_rs_i),
    .id_use_rt_i   (id_use_rt_i),
    .ex_rd_i       (ex_rd_i),
    .ex_we_i       (ex_regwrite_i),
    .mem_rd_i      (mem_rd_i),
    .mem_we_i      (mem_regwrite_i),
    .mem_load_i    (mem_memread_i),
    .other_stall_i (ld_stall),
    .br_stall_o    (br_stall),
    .fwd_a_o       (id_fwd_a_o),
    .fwd_b_o       (id_fwd_b_o),
    .flush_o       (flush_o)
  );

  assign stall_o  = ld_stall || br_stall;
  assign bubble_o = ld_stall || br_stall;
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
  parameter int unsigned AW = 5
) (
  input logic [AW-1:0] id_rs_i,
  input logic          id_use_rs_i,
  input logic          id_branch_i,
  input logic          br_taken_i,
  input logic [AW-1:0] ex_rs_i,
  input logic [AW-1:0] ex_rt_i,
  input logic [AW-1:0] ex_rd_i,
  input logic          ex_memread_i,
  input logic [AW-1:0] mem_rd_i,
  input logic          mem_regwrite_i,
  input logic [1:0]    ex_fwd_a_o,
  input logic [1:0]    ex_fwd_b_o,
  input logic          stall_o,
  input logic          bubble_o,
  input logic          flush_o
);
  localparam logic [AW-1:0] ZERO_IDX = '0;

  always_comb begin
    // R1
    exmem_src_chk: assert (ex_fwd_a_o != 2'b10 ||
      (mem_regwrite_i && mem_rd_i != ZERO_IDX && mem_rd_i == ex_rs_i));
    // R2
    sel_code_chk: assert (ex_fwd_a_o != 2'b11 && ex_fwd_b_o != 2'b11);
    // R4
    zero_fwd_chk: assert (!(ex_rs_i == ZERO_IDX && ex_fwd_a_o != 2'b00) &&
                          !(ex_rt_i == ZERO_IDX && ex_fwd_b_o != 2'b00));
    // R5
    load_use_chk: assert (!(ex_memread_i && ex_rd_i != ZERO_IDX && id_use_rs_i &&
                            ex_rd_i == id_rs_i) || (stall_o && bubble_o));
    // R8
    flush_src_chk: assert (!flush_o || (id_branch_i && br_taken_i));
    // R9
    stall_flush_chk: assert (!(stall_o && flush_o));
  end
endmodule

bind hzd_unit hzd_unit_chk #(.AW(AW)) chk_i (
  .id_rs_i        (id_rs_i),
  .id_use_rs_i    (id_use_rs_i),
  .id_branch_i    (id_branch_i),
  .br_taken_i     (br_taken_i),
  .ex_rs_i        (ex_rs_i),
  .ex_rt_i        (ex_rt_i),
  .ex_rd_i        (ex_rd_i),
  .ex_memread_i   (ex_memread_i),
  .mem_rd_i       (mem_rd_i),
  .mem_regwrite_i (mem_regwrite_i),
  .ex_fwd_a_o     (ex_fwd_a_o),
  .ex_fwd_b_o     (ex_fwd_b_o),
  .stall_o        (stall_o),
  .bubble_o       (bubble_o),
  .flush_o        (flush_o)
);

// File: tb/hzd_unit_tb_top.sv
`timescale 1ns/1ps
module hzd_unit_tb_top;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic id_use_rs, id_use_rt, id_branch, br_taken;
  logic ex_we, ex_ld, mem_we, mem_ld, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic idf_a, idf_b, stall, bubble, flush;

  int checks = 0;
  int errors = 0;
  string tag = "R4 reset idle";

  hzd_unit #(.AW(AW)) dut_i (
    .id_rs_i(id_rs), .id_rt_i(id_rt), .id_use_rs_i(id_use_rs), .id_use_rt_i(id_use_rt),
    .id_branch_i(id_branch), .br_taken_i(br_taken),
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt), .ex_rd_i(ex_rd),
    .ex_regwrite_i(ex_we), .ex_memread_i(ex_ld),
    .mem_rd_i(mem_rd), .mem_regwrite_i(mem_we), .mem_memread_i(mem_ld),
    .wb_rd_i(wb_rd), .wb_regwrite_i(wb_we),
    .ex_fwd_a_o(fwd_a), .ex_fwd_b_o(fwd_b), .id_fwd_a_o(idf_a), .id_fwd_b_o(idf_b),
    .stall_o(stall), .bubble_o(bubble), .flush_o(flush)
  );

  task automatic clear();
    id_rs = 0; id_rt = 0; ex_rs = 0; ex_rt = 0; ex_rd = 0; mem_rd = 0; wb_rd = 0;
    id_use_rs = 0; id_use_rt = 0; id_branch = 0; br_taken = 0;
    ex_we = 0; ex_ld = 0; mem_we = 0; mem_ld = 0; wb_we = 0;
  endtask

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // behavioural reference: expected select code for one execute operand
  function automatic int ref_sel(int src);
    if (src != 0 && mem_we && int'(mem_rd) == src) return 2;
    if (src != 0 && wb_we && int'(wb_rd) == src) return 1;
    return 0;
  endfunction

  task automatic compare();
    int srcs[2];
    int uses[2];
    int ld_hold, br_hold, exp_stall, exp_flush;
    int byp[2];
    srcs[0] = int'(id_rs); srcs[1] = int'(id_rt);
    uses[0] = int'(id_use_rs); uses[1] = int'(id_use_rt);
    ld_hold = 0; br_hold = 0; byp[0] = 0; byp[1] = 0;
    foreach (srcs[k]) begin
      if (uses[k] != 0 && srcs[k] != 0) begin
        if (ex_ld && int'(ex_rd) == srcs[k]) ld_hold = 1;
        if (id_branch && ex_we && int'(ex_rd) == srcs[k]) br_hold = 1;
        if (id_branch && mem_we && int'(mem_rd) == srcs[k]) begin
          if (mem_ld) br_hold = 1;
          else byp[k] = 1;
        end
      end
    end
    exp_stall = (ld_hold != 0 || br_hold != 0) ? 1 : 0;
    exp_flush = (id_branch && br_taken && exp_stall == 0) ? 1 : 0;
    chk("ex_fwd_a", int'(fwd_a), ref_sel(int'(ex_rs)));
    chk("ex_fwd_b", int'(fwd_b), ref_sel(int'(ex_rt)));
    chk("id_fwd_a", int'(idf_a), byp[0]);
    chk("id_fwd_b", int'(idf_b), byp[1]);
    chk("stall",    int'(stall), exp_stall);
    chk("bubble",   int'(bubble), exp_stall);
    chk("flush",    int'(flush), exp_flush);
  endtask

  // compare on every clock, away from the driving edge
  always @(negedge clk) compare();

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    clear();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    tag = "R1 exmem bypass"; clear();
    ex_rs = 3; mem_rd = 3; mem_we = 1; step();
    @(negedge clk); chk("R1 direct", int'(fwd_a), 2);

    tag = "R2 memwb bypass"; clear();
    ex_rt = 4; wb_rd = 4; wb_we = 1; ex_rs = 4; mem_rd = 4; mem_we = 0; step();

    tag = "R3 both match"; clear();
    ex_rs = 5; mem_rd = 5; mem_we = 1; wb_rd = 5; wb_we = 1; step();
    @(negedge clk); chk("R3 direct", int'(fwd_a), 2);

    tag = "R4 zero register"; clear();
    mem_we = 1; wb_we = 1; ex_ld = 1; ex_we = 1; id_use_rs = 1; id_use_rt = 1;
    id_branch = 1; br_taken = 1; step();

    tag = "R5 load use"; clear();
    ex_ld = 1; ex_we = 1; ex_rd = 7; id_rt = 7; id_use_rt = 1; step();
    @(negedge clk); chk("R5 direct", int'(stall), 1);
    tag = "R5 unused source"; id_use_rt = 0; step();

    tag = "R6 R9 branch after ALU"; clear();
    id_branch = 1; br_taken = 1; id_rs = 6; id_use_rs = 1; ex_rd = 6; ex_we = 1; step();
    @(negedge clk); chk("R9 direct", int'(flush), 0);

    tag = "R7 branch after load in mem"; clear();
    id_branch = 1; br_taken = 1; id_rt = 6; id_use_rt = 1;
    mem_rd = 6; mem_we = 1; mem_ld = 1; step();
    tag = "R7 R8 branch takes mem bypass"; mem_ld = 0; step();
    @(negedge clk); chk("R8 direct", int'(flush), 1);
    tag = "R8 not taken"; br_taken = 0; step();

    tag = "R6 R7 R9 double producer"; clear();
    id_branch = 1; br_taken = 1; id_rs = 2; id_rt = 9; id_use_rs = 1; id_use_rt = 1;
    ex_rd = 9; ex_we = 1; mem_rd = 2; mem_we = 1; mem_ld = 1; step();

    tag = "random mix R1 R2 R3 R4 R5 R6 R7 R8 R9";
    for (int i = 0; i < 3000; i++) begin
      id_rs = AW'($urandom_range(0, 3)); id_rt = AW'($urandom_range(0, 3));
      ex_rs = AW'($urandom_range(0, 3)); ex_rt = AW'($urandom_range(0, 3));
      ex_rd = AW'($urandom_range(0, 3)); mem_rd = AW'($urandom_range(0, 3));
      wb_rd = AW'($urandom_range(0, 3));
      id_use_rs = 1'($urandom); id_use_rt = 1'($urandom);
      id_branch = 1'($urandom); br_taken = 1'($urandom);
      ex_we = 1'($urandom); ex_ld = ex_we & 1'($urandom);
      mem_we = 1'($urandom); mem_ld = mem_we & 1'($urandom);
      wb_we = 1'($urandom);
      step();
    end
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule